// File: doc/BRIEF.md
# Receiver Equalizer Adaptation Hint Sequencer

This block drives the 3-bit preset-hint code that selects how a serial receiver's continuous-time linear equalizer behaves. At the two lower line rates the equalizer must run in manual mode, so the hint is held at `3'b000`. At the highest rate the equalizer is run in triggered adaptation mode. Here the hint is raised to `3'b111` at the right moment and then left there for as long as the link stays at that rate.

The moment of triggering depends on the link's history. On the first arrival at the high rate, and after equalization is started again, the trigger waits for the far-end transmitter preset or coefficient requests to finish during equalization phase 2 or 3. On a return to the high rate after a down-train, when equalization has already been done once, the trigger waits only for valid receive data. Each trigger opens a dwell window of about 12 ms. Throughout that window the block raises a request asking the link controller to keep the link in recovery. Only cycles spent in recovery count toward the window. This lets the dwell run on past the end of equalization into receiver lock.

Top module: `ctle_hint_seq`

## Requirements
- R1: While reset (`rst_n` low, sampled on a clock edge) is applied, and after it is released, `rx_hint` is `3'b000` and `hold_recovery` is 0.
- R2: In the cycle after any clock edge that sees `rate_hi` low, `rx_hint` is `3'b000` and `hold_recovery` is 0, even if a dwell was running.
- R3: After the first entry to the high rate, `rx_hint` stays `3'b000` until `far_req_done` is sampled high while `eq_phase` is 2 or 3 (`2'd2`, `2'd3`). A strobe in phase 0 or 1, and `data_valid` alone, have no effect. The edge that first sees `rate_hi` high only records the entry.
- R4: One cycle after an accepted trigger, `rx_hint` becomes `3'b111` and `hold_recovery` becomes 1.
- R5: `hold_recovery` stays 1 until `DWELL_CYCLES` clock edges with `in_recovery` high have been seen after the trigger edge. Edges with `in_recovery` low do not count, and `eq_phase` has no effect on the count. `hold_recovery` is never 1 while `rx_hint` is `3'b000`.
- R6: Once `rx_hint` is `3'b111`, it stays `3'b111` while `rate_hi` remains high. Changes of `in_recovery`, `data_valid`, `far_req_done`, the dwell expiring, and later recovery visits all leave it there. Only the conditions in R2 and R7 clear it.
- R7: At the high rate, `redo_eq` sampled high while `eq_phase` is 2 or 3 clears `rx_hint` to `3'b000` and `hold_recovery` to 0 in the next cycle. The block then waits for a trigger as in R3. `redo_eq` in phase 0 or 1 has no effect.
- R8: On a return to the high rate after a down-train, once adaptation has happened at least once, the trigger is `data_valid` sampled high. `far_req_done` alone has no effect. The trigger leads to the R4 behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rate_hi | input | 1 | 1 = highest line rate, 0 = either lower rate |
| eq_phase | input | 2 | Current equalization phase, 0 to 3 |
| far_req_done | input | 1 | Strobe: far-end transmitter requests complete |
| data_valid | input | 1 | Receiver has valid data |
| in_recovery | input | 1 | Link is in a recovery substate |
| redo_eq | input | 1 | Equalization is being performed again |
| rx_hint | output | 3 | Equalizer preset hint: 000 manual, 111 triggered adaptation |
| hold_recovery | output | 1 | Request to keep the link in recovery until the dwell ends |

## Verification
The assertions assume that every input is a clean, synchronous level sampled on the rising edge. They also assume that `redo_eq` and `far_req_done` mean something only at the high rate. The checks on the dwell counter assume that `DWELL_CYCLES` is at least 1.

The stimulus drives every input just after the falling clock edge, and it keeps `DWELL_CYCLES` short. This lets whole dwell windows, including windows with gaps in `in_recovery`, complete during the run. The stimulus also pulses `redo_eq` and strobes `far_req_done` in phases 0 and 1 as well as in phases 2 and 3.

// File: rtl/ctle_hint_pkg.sv
// Shared types for the equalizer adaptation hint sequencer.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package ctle_hint_pkg;
    typedef enum logic [1:0] {
        HS_MANUAL     = 2'd0,  // lower line rate, manual equalizer
        HS_WAIT_REQ   = 2'd1,  // high rate, awaiting far-end request completion
        HS_WAIT_VALID = 2'd2,  // high rate re-entry, awaiting valid data
        HS_ADAPTED    = 2'd3   // triggered adaptation active
    } hint_state_e;

    localparam logic [2:0] HINT_MANUAL = 3'b000;
    localparam logic [2:0] HINT_ADAPT  = 3'b111;
endpackage

// File: rtl/ctle_hint_fsm.sv
// Episode state machine: tracks line rate, equalization history and the
// trigger condition for adaptation. Assumes synchronous inputs; the phase
// code 2 or 3 marks the far-end tuning phases.
module ctle_hint_fsm
    import ctle_hint_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rate_hi,
    input  logic [1:0] eq_phase,
    input  logic       far_req_done,
    input  logic       data_valid,
    input  logic       redo_eq,
    output logic       adapt_q,
    output logic       adapt_start,
    output logic       adapt_nxt
);
    hint_state_e st_q, st_d;
    logic        eq_done_q;
    logic        tune_phase;

    assign tune_phase = (eq_phase == 2'd2) || (eq_phase == 2'd3);

    // Next-state selection: rate drop first, then redo, then triggers.
    always_comb begin
        st_d = st_q;
        if (!rate_hi) begin
            st_d = HS_MANUAL;
        end else if (st_q == HS_MANUAL) begin
            st_d = eq_done_q ? HS_WAIT_VALID : HS_WAIT_REQ;
        end else if (redo_eq && tune_phase) begin
            st_d = HS_WAIT_REQ;
        end else begin
            case (st_q)
                HS_WAIT_REQ:   if (far_req_done && tune_phase) st_d = HS_ADAPTED;
                HS_WAIT_VALID: if (data_valid) st_d = HS_ADAPTED;
                default:       st_d = st_q;
            endcase
        end
    end

    // State and equalization-history registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= HS_MANUAL;
            eq_done_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (st_d == HS_ADAPTED) eq_done_q <= 1'b1;
        end
    end

    assign adapt_q     = (st_q == HS_ADAPTED);
    assign adapt_nxt   = (st_d == HS_ADAPTED);
    assign adapt_start = adapt_nxt && !adapt_q;

    // R3 R4 R8
    // Adaptation only begins after an accepted strobe or valid data.
    trigger_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adapt_q) |-> $past(far_req_done || data_valid));

    // R6
    hint_persist_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adapt_q && rate_hi && !(redo_eq && tune_phase) |=> adapt_q);

    // R7
    redo_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adapt_q && rate_hi && redo_eq && tune_phase |=> !adapt_q);
endmodule

// File: rtl/ctle_dwell_timer.sv
// Dwell timer: counts recovery cycles after an adaptation trigger and
// reports busy until DWELL_CYCLES of them have passed. Assumes
// DWELL_CYCLES >= 1; 'keep' low aborts the window at once.
module ctle_dwell_timer #(
    parameter int DWELL_CYCLES = 3_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic keep,
    input  logic tick,
    output logic busy
);
    localparam int CNT_W = $clog2(DWELL_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DWELL_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;

    // Window counter: load on start, advance on ticks, stop at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !keep) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
        end else if (busy_q && tick) begin
            if (cnt_q == LAST) begin
                busy_q <= 1'b0;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign busy = busy_q;

    // R5
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R5
    // The window closes only on a counted tick or an abort.
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> $past(tick || !keep));
endmodule

// File: rtl/ctle_hint_seq.sv
// Top: equalizer preset-hint sequencer. Combines the episode state machine
// with the dwell timer and drives the hint code and recovery-hold request.
// Assumes all inputs synchronous to clk.
module ctle_hint_seq
    import ctle_hint_pkg::*;
#(
    parameter int CLK_HZ       = 250_000_000,
    parameter int DWELL_MS     = 12,
    parameter int DWELL_CYCLES = CLK_HZ / 1000 * DWELL_MS
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rate_hi,
    input  logic [1:0] eq_phase,
    input  logic       far_req_done,
    input  logic       data_valid,
    input  logic       in_recovery,
    input  logic       redo_eq,
    output logic [2:0] rx_hint,
    output logic       hold_recovery
);
    logic adapt_q, adapt_start, adapt_nxt, busy;

    ctle_hint_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .rate_hi      (rate_hi),
        .eq_phase     (eq_phase),
        .far_req_done (far_req_done),
        .data_valid   (data_valid),
        .redo_eq      (redo_eq),
        .adapt_q      (adapt_q),
        .adapt_start  (adapt_start),
        .adapt_nxt    (adapt_nxt)
    );

    ctle_dwell_timer #(.DWELL_CYCLES(DWELL_CYCLES)) u_dwell (
        .clk   (clk),
        .rst_n (rst_n),
        .start (adapt_start),
        .keep  (adapt_nxt),
        .tick  (in_recovery),
        .busy  (busy)
    );

    // Output mapping: hint code from state, hold from the dwell window.
    always_comb begin
        rx_hint       = adapt_q ? HINT_ADAPT : HINT_MANUAL;
        hold_recovery = busy;
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (rx_hint == HINT_MANUAL) && !hold_recovery);

    // R2
    low_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rate_hi |=> (rx_hint == HINT_MANUAL) && !hold_recovery);

    // R5
    hold_needs_hint_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_recovery |-> (rx_hint == HINT_ADAPT));
endmodule

// File: tb/sim_ctle_hint_seq.sv
module sim_ctle_hint_seq;
    localparam int L = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rate_hi = 1'b0;
    logic [1:0] eq_phase = 2'd0;
    logic       far_req_done = 1'b0;
    logic       data_valid = 1'b0;
    logic       in_recovery = 1'b0;
    logic       redo_eq = 1'b0;
    logic [2:0] rx_hint;
    logic       hold_recovery;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    // Behavioural reference: mode 0 low rate, 1 await requests,
    // 2 await valid data, 3 adapted.
    int   m_mode = 0;
    bit   m_ever = 1'b0;
    int   m_rem  = 0;
    logic [2:0] exp_hint = 3'b000;
    bit   exp_hold = 1'b0;

    always #5 clk = ~clk;

    ctle_hint_seq #(.DWELL_CYCLES(L)) u0 (
        .clk(clk), .rst_n(rst_n), .rate_hi(rate_hi), .eq_phase(eq_phase),
        .far_req_done(far_req_done), .data_valid(data_valid),
        .in_recovery(in_recovery), .redo_eq(redo_eq),
        .rx_hint(rx_hint), .hold_recovery(hold_recovery)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_ever = 1'b0; m_rem = 0;
        end else if (!rate_hi) begin
            m_mode = 0; m_rem = 0;
        end else if (m_mode == 0) begin
            m_mode = m_ever ? 2 : 1;
        end else if (redo_eq && eq_phase >= 2) begin
            m_mode = 1; m_rem = 0;
        end else if (m_mode == 1 && far_req_done && eq_phase >= 2) begin
            m_mode = 3; m_ever = 1'b1; m_rem = L;
        end else if (m_mode == 2 && data_valid) begin
            m_mode = 3; m_rem = L;
        end else if (m_mode == 3 && m_rem > 0 && in_recovery) begin
            m_rem = m_rem - 1;
        end
        exp_hint = (m_mode == 3) ? 3'b111 : 3'b000;
        exp_hold = (m_rem > 0);
    end

    // Compare against the model on every falling edge.
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (rx_hint !== exp_hint || hold_recovery !== exp_hold) begin
                errors++;
                $display("FAIL %s: hint=%b hold=%b expected hint=%b hold=%b at %0t",
                         cur_req, rx_hint, hold_recovery, exp_hint, exp_hold, $time);
            end
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
        #1;
    endtask

    task automatic expect_out(input string req, input logic [2:0] h, input bit hd);
        checks++;
        if (rx_hint !== h || hold_recovery !== hd) begin
            errors++;
            $display("FAIL %s: hint=%b hold=%b expected hint=%b hold=%b",
                     req, rx_hint, hold_recovery, h, hd);
        end
    endtask

    initial begin
        cur_req = "R1"; cyc(3);
        expect_out("R1", 3'b000, 1'b0);
        rst_n = 1'b1; cyc(2);
        expect_out("R1", 3'b000, 1'b0);

        // R3: first entry, wrong-phase strobe and valid data ignored
        cur_req = "R3"; rate_hi = 1'b1; eq_phase = 2'd0; cyc(2);
        far_req_done = 1'b1; cyc(1); far_req_done = 1'b0;
        eq_phase = 2'd1; far_req_done = 1'b1; cyc(1); far_req_done = 1'b0;
        data_valid = 1'b1; cyc(3);
        expect_out("R3", 3'b000, 1'b0);

        // R4: accepted strobe in phase 2
        cur_req = "R4"; eq_phase = 2'd2; far_req_done = 1'b1; cyc(1);
        far_req_done = 1'b0;
        expect_out("R4", 3'b111, 1'b1);

        // R5: dwell with gaps in recovery and phase moving on
        cur_req = "R5";
        for (int i = 0; i < 30; i++) begin
            in_recovery = (i % 3) != 1;
            eq_phase = (i > 10) ? 2'd0 : 2'd3;
            cyc(1);
        end
        in_recovery = 1'b1; cyc(L);
        expect_out("R5", 3'b111, 1'b0);

        // R6: hint persists through later recovery visits
        cur_req = "R6";
        for (int i = 0; i < 10; i++) begin
            in_recovery = i[0]; data_valid = i[1]; far_req_done = i[2];
            cyc(1);
        end
        far_req_done = 1'b0;
        expect_out("R6", 3'b111, 1'b0);

        // R7: redo in phase 1 ignored, in phase 3 clears
        cur_req = "R7"; eq_phase = 2'd1; redo_eq = 1'b1; cyc(1);
        expect_out("R7", 3'b111, 1'b0);
        eq_phase = 2'd3; cyc(1); redo_eq = 1'b0;
        expect_out("R7", 3'b000, 1'b0);
        cyc(2);
        far_req_done = 1'b1; cyc(1); far_req_done = 1'b0;
        expect_out("R7", 3'b111, 1'b1);
        cyc(5);

        // R2: rate drop mid-dwell
        cur_req = "R2"; rate_hi = 1'b0; cyc(1);
        expect_out("R2", 3'b000, 1'b0);
        cyc(3);

        // R8: re-entry waits on valid data, not on the strobe
        cur_req = "R8"; data_valid = 1'b0; rate_hi = 1'b1; eq_phase = 2'd2; cyc(2);
        far_req_done = 1'b1; cyc(2); far_req_done = 1'b0;
        expect_out("R8", 3'b000, 1'b0);
        data_valid = 1'b1; cyc(1);
        expect_out("R8", 3'b111, 1'b1);
        in_recovery = 1'b1; cyc(L + 3);

        // R2 and R8: re-entry with valid already high on the entry edge
        cur_req = "R2"; rate_hi = 1'b0; cyc(2);
        expect_out("R2", 3'b000, 1'b0);
        cur_req = "R8"; rate_hi = 1'b1; cyc(1);
        expect_out("R8", 3'b000, 1'b0);
        cyc(1);
        expect_out("R8", 3'b111, 1'b1);
        cyc(L + 3);

        // R1: reset in the adapted state
        cur_req = "R1"; rst_n = 1'b0; cyc(1);
        expect_out("R1", 3'b000, 1'b0);
        rst_n = 1'b1; cyc(2);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule